// File: doc/BRIEF.md
# Long Shift and Normalize Engine

This block performs multi-cycle shifts on an 18-bit accumulator (AC), on its 18-bit extension register (MQ) and on a one-bit link. The shifts work on the 36-bit AC:MQ pair or on AC alone. It also performs normalization. The block moves data one place per clock. A 6-bit step counter (SC) paces the operation: it counts up from the ones' complement of the requested count and ends the operation when it wraps to zero. A normalize operation also ends early when the two most significant AC bits differ.

A command strobe delivers an operation code, a 6-bit count and the starting AC, MQ and link values. The block raises `busy` while it works and holds the final registers on its outputs afterwards. SC stays readable after the command, and a dedicated input clears it while the block is idle. An interrupt-hold output tells the surrounding processor when it must not grant a pending device interrupt. That is while a shift is running, and after a normalize until two more instructions have retired.

Top module: `shift_norm_engine`

## Requirements
- R1: After a synchronous active-low reset, AC, MQ, link and SC are all zero, and `busy` and `irq_hold` are low.
- R2: A command is accepted at a rising edge where `cmd_valid` is high and `busy` is low. The op codes are 0 long left, 1 signed long left, 2 long right, 3 signed long right, 4 accumulator left, 5 normalize and 6 signed normalize. Op code 7, and any command presented while `busy` is high, is ignored and changes no register.
- R3: One step of a long left shift moves AC:MQ up one place. The MSB of MQ (MQ[17]) enters the LSB of AC (AC[0]), and the link enters MQ[0]. AC[17] is lost and the link is unchanged.
- R4: One step of a long right shift moves the link into AC[17] and AC[0] into MQ[17]. MQ[0] is lost and the link is unchanged.
- R5: The signed forms (op 1, 3 and 6) copy AC[17] into the link before the first step, so the vacated positions fill with the sign.
- R6: One step of an accumulator left shift moves only AC: the link enters AC[0]. MQ and the link are unchanged, and MQ does not enter AC.
- R7: A shift with count N performs exactly N steps, for N from 0 to 63 (the intended range is 0 to 36). A count of 0 leaves AC, MQ and the link unchanged, apart from the sign copy of R5.
- R8: SC loads the ones' complement of the count on acceptance. It increments once in a set-up cycle and once per step, wrapping from 63 to 0, and it reads 0 after a shift that ran its full count.
- R9: `sc_clr` sampled high while idle clears SC to 0.
- R10: A normalize shifts like a long left shift. Before each step it stops if AC[17] differs from AC[16], and SC is left at the number of steps taken minus N (mod 64). A count of 1 on a value that is already normalized therefore leaves SC at 63.
- R11: `busy` is high for exactly K+2 cycles after the accepting edge, where K is the number of steps performed.
- R12: `irq_hold` is high whenever `busy` is high. After a plain shift it falls together with `busy`. After a normalize it stays high until two `instr_done` pulses have been seen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_valid | input | 1 | Command strobe |
| cmd_op | input | 3 | Operation code (see R2) |
| cmd_count | input | 6 | Requested number of places |
| cmd_ac | input | 18 | Starting AC value |
| cmd_mq | input | 18 | Starting MQ value |
| cmd_link | input | 1 | Starting link value |
| sc_clr | input | 1 | Clear step counter when idle |
| instr_done | input | 1 | One pulse per retired instruction |
| ac_out | output | 18 | Current AC |
| mq_out | output | 18 | Current MQ |
| link_out | output | 1 | Current link |
| sc_out | output | 6 | Step counter readback |
| busy | output | 1 | Operation in progress |
| irq_hold | output | 1 | Interrupt grant must be withheld |

## Verification
The corner cases are the boundary bits and the stop rules. If the link wrongly enters AC[0] on a long left shift, or AC[0] leaks into the link on a right shift, the vectors that carry a lone one across the AC/MQ seam or out of the word show it. A count of zero must leave all registers as loaded, and a normalize that starts on an already normalized value must stop at once with SC at 63. An engine that counted down, or that took one extra step, would show a wrong SC or a wrong busy length. The interrupt hold is checked across the two-instruction tail after a normalize, and also for its absence after a plain shift. Commands and op code 7 sent while busy are checked to leave the result untouched.

// File: rtl/shn_pkg.sv
// Shared types for the long shift and normalize engine.
// Assumes 3-bit op codes fixed by the command interface.
package shn_pkg;
    typedef enum logic [2:0] {
        OP_LSH   = 3'd0,
        OP_LSH_S = 3'd1,
        OP_RSH   = 3'd2,
        OP_RSH_S = 3'd3,
        OP_ACL   = 3'd4,
        OP_NRM   = 3'd5,
        OP_NRM_S = 3'd6,
        OP_NONE  = 3'd7
    } shn_op_e;

    typedef enum logic [1:0] {ST_IDLE, ST_PREP, ST_RUN} shn_state_e;

    typedef enum logic [1:0] {DIR_LONG_L, DIR_LONG_R, DIR_ACC_L} shn_dir_e;

    function automatic logic op_is_signed(shn_op_e op);
        return (op == OP_LSH_S) || (op == OP_RSH_S) || (op == OP_NRM_S);
    endfunction

    function automatic logic op_is_norm(shn_op_e op);
        return (op == OP_NRM) || (op == OP_NRM_S);
    endfunction

    function automatic shn_dir_e op_dir(shn_op_e op);
        case (op)
            OP_RSH, OP_RSH_S: return DIR_LONG_R;
            OP_ACL:           return DIR_ACC_L;
            default:          return DIR_LONG_L;
        endcase
    endfunction
endpackage

// File: rtl/shn_step_ctr.sv
// Step counter: loads the ones' complement of the count, counts up,
// wraps to zero. Assumes the caller only asserts clr when idle.
module shn_step_ctr #(
    parameter int SC_W = 6
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            clr,
    input  logic            load,
    input  logic [SC_W-1:0] load_cnt,
    input  logic            inc,
    output logic [SC_W-1:0] sc,
    output logic            zero
);
    // Counter register: load has priority over increment and clear.
    always_ff @(posedge clk) begin
        if (!rst_n)      sc <= '0;
        else if (load)   sc <= ~load_cnt;
        else if (inc)    sc <= sc + 1'b1;
        else if (clr)    sc <= '0;
    end

    // Terminal (wrapped) value detect.
    assign zero = (sc == '0);
endmodule

// File: rtl/shn_shifter.sv
// Datapath: AC, MQ and link registers with one-place long left, long
// right and accumulator-only left moves. The link changes only on load
// or on the sign copy.
module shn_shifter
    import shn_pkg::*;
#(
    parameter int WORD_W = 18
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [WORD_W-1:0] ld_ac,
    input  logic [WORD_W-1:0] ld_mq,
    input  logic              ld_link,
    input  logic              sign_fill,
    input  logic              step,
    input  shn_dir_e          dir,
    output logic [WORD_W-1:0] ac,
    output logic [WORD_W-1:0] mq,
    output logic              link
);
    // Register update: load, sign copy, or one shift step.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ac   <= '0;
            mq   <= '0;
            link <= 1'b0;
        end else if (load) begin
            ac   <= ld_ac;
            mq   <= ld_mq;
            link <= ld_link;
        end else if (sign_fill) begin
            link <= ac[WORD_W-1];
        end else if (step) begin
            case (dir)
                DIR_LONG_L: {ac, mq} <= {ac[WORD_W-2:0], mq, link};
                DIR_LONG_R: {ac, mq} <= {link, ac, mq[WORD_W-1:1]};
                DIR_ACC_L:  ac       <= {ac[WORD_W-2:0], link};
                default:    ac       <= ac;
            endcase
        end
    end
endmodule

// File: rtl/shn_ctrl.sv
// Sequencer: idle, one set-up cycle, then run cycles that either step
// or stop. Stops on SC zero or, for normalize, on differing top AC bits.
module shn_ctrl
    import shn_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cmd_valid,
    input  logic [2:0] cmd_op,
    input  logic       sc_zero,
    input  logic [1:0] ac_top2,
    output logic       accept,
    output logic       prep,
    output logic       step,
    output logic       done,
    output logic       busy,
    output shn_op_e    op_q
);
    shn_state_e state_q;
    logic       stop;
    logic       norm_stop;

    // Acceptance and per-cycle decode.
    always_comb begin
        accept    = (state_q == ST_IDLE) && cmd_valid && (shn_op_e'(cmd_op) != OP_NONE);
        prep      = (state_q == ST_PREP);
        norm_stop = op_is_norm(op_q) && (ac_top2[1] != ac_top2[0]);
        stop      = (state_q == ST_RUN) && (sc_zero || norm_stop);
        step      = (state_q == ST_RUN) && !stop;
        done      = stop;
        busy      = (state_q != ST_IDLE);
    end

    // State and latched op code.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            op_q    <= OP_LSH;
        end else begin
            case (state_q)
                ST_IDLE: if (accept) begin
                    state_q <= ST_PREP;
                    op_q    <= shn_op_e'(cmd_op);
                end
                ST_PREP: state_q <= ST_RUN;
                ST_RUN:  if (stop) state_q <= ST_IDLE;
                default: state_q <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/shn_irq_hold.sv
// Interrupt hold: high while busy and for HOLD_N retired instructions
// after a normalize finishes.
module shn_irq_hold #(
    parameter int HOLD_N = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic busy,
    input  logic norm_done,
    input  logic instr_done,
    output logic irq_hold
);
    localparam int CW = $clog2(HOLD_N + 1);
    logic [CW-1:0] tail_q;

    // Tail counter: armed by a normalize finish, drained by retirements.
    always_ff @(posedge clk) begin
        if (!rst_n)                          tail_q <= '0;
        else if (norm_done)                  tail_q <= CW'(HOLD_N);
        else if (instr_done && tail_q != '0) tail_q <= tail_q - 1'b1;
    end

    // Hold output.
    assign irq_hold = busy || (tail_q != '0);
endmodule

// File: rtl/shift_norm_engine.sv
// Top: long shift / normalize engine over AC:MQ and link with a 6-bit
// up-counting step counter. Operands arrive with the command strobe.
module shift_norm_engine
    import shn_pkg::*;
#(
    parameter int WORD_W = 18,
    parameter int SC_W   = 6,
    parameter int HOLD_N = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid,
    input  logic [2:0]        cmd_op,
    input  logic [SC_W-1:0]   cmd_count,
    input  logic [WORD_W-1:0] cmd_ac,
    input  logic [WORD_W-1:0] cmd_mq,
    input  logic              cmd_link,
    input  logic              sc_clr,
    input  logic              instr_done,
    output logic [WORD_W-1:0] ac_out,
    output logic [WORD_W-1:0] mq_out,
    output logic              link_out,
    output logic [SC_W-1:0]   sc_out,
    output logic              busy,
    output logic              irq_hold
);
    logic    accept, prep, step, done, sc_zero;
    shn_op_e op_q;
    logic [1:0] ac_top2;

    assign ac_top2 = ac_out[WORD_W-1 -: 2];

    shn_ctrl u_ctrl (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
        .sc_zero(sc_zero), .ac_top2(ac_top2), .accept(accept), .prep(prep),
        .step(step), .done(done), .busy(busy), .op_q(op_q)
    );

    shn_step_ctr #(.SC_W(SC_W)) u_sc (
        .clk(clk), .rst_n(rst_n), .clr(sc_clr && !busy), .load(accept),
        .load_cnt(cmd_count), .inc(prep || step), .sc(sc_out), .zero(sc_zero)
    );

    shn_shifter #(.WORD_W(WORD_W)) u_dp (
        .clk(clk), .rst_n(rst_n), .load(accept), .ld_ac(cmd_ac),
        .ld_mq(cmd_mq), .ld_link(cmd_link),
        .sign_fill(prep && op_is_signed(op_q)), .step(step),
        .dir(op_dir(op_q)), .ac(ac_out), .mq(mq_out), .link(link_out)
    );

    shn_irq_hold #(.HOLD_N(HOLD_N)) u_irq (
        .clk(clk), .rst_n(rst_n), .busy(busy),
        .norm_done(done && op_is_norm(op_q)), .instr_done(instr_done),
        .irq_hold(irq_hold)
    );
endmodule

// File: rtl/shift_norm_engine_chk.sv
// Checker for shift_norm_engine, attached by bind below.
module shift_norm_engine_chk #(
    parameter int WORD_W = 18,
    parameter int SC_W   = 6
) (
    input logic              clk,
    input logic              rst_n,
    input logic              busy,
    input logic              step,
    input logic              done,
    input logic [2:0]        op_q,
    input logic [SC_W-1:0]   sc,
    input logic [WORD_W-1:0] mq,
    input logic              link,
    input logic [1:0]        ac_top2,
    input logic              irq_hold
);
    // SC advances by exactly one per shift step.
    assert_step_inc_R8: assert property (@(posedge clk) disable iff (!rst_n)
        step |=> sc == $past(sc) + 1'b1);

    // No shift step touches the link.
    assert_link_steady_R3: assert property (@(posedge clk) disable iff (!rst_n)
        step |=> $stable(link));

    // Accumulator-only shift leaves MQ alone.
    assert_acc_mq_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (step && op_q == 3'd4) |=> $stable(mq));

    // A normalize step only occurs while the top AC bits agree.
    assert_norm_step_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (step && (op_q == 3'd5 || op_q == 3'd6)) |-> (ac_top2[1] == ac_top2[0]));

    // Latched op stays fixed while busy.
    assert_ignore_busy_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !done) |=> $stable(op_q));

    // Finish returns to idle on the next edge.
    assert_done_idle_R11: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !busy);

    // Interrupt hold covers every busy cycle.
    assert_hold_busy_R12: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> irq_hold);
endmodule

bind shift_norm_engine shift_norm_engine_chk #(.WORD_W(WORD_W), .SC_W(SC_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .busy(busy), .step(step), .done(done),
    .op_q(op_q), .sc(sc_out), .mq(mq_out), .link(link_out),
    .ac_top2(ac_top2), .irq_hold(irq_hold)
);

// File: tb/shift_norm_engine_tb.sv
`timescale 1ns/1ps
module shift_norm_engine_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_valid = 1'b0;
    logic [2:0]  cmd_op = '0;
    logic [5:0]  cmd_count = '0;
    logic [17:0] cmd_ac = '0, cmd_mq = '0;
    logic        cmd_link = 1'b0;
    logic        sc_clr = 1'b0;
    logic        instr_done = 1'b0;
    logic [17:0] ac_out, mq_out;
    logic        link_out, busy, irq_hold;
    logic [5:0]  sc_out;

    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    shift_norm_engine u_dut (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
        .cmd_count(cmd_count), .cmd_ac(cmd_ac), .cmd_mq(cmd_mq),
        .cmd_link(cmd_link), .sc_clr(sc_clr), .instr_done(instr_done),
        .ac_out(ac_out), .mq_out(mq_out), .link_out(link_out),
        .sc_out(sc_out), .busy(busy), .irq_hold(irq_hold)
    );

    // Stimulus vectors: {op[2:0], count[5:0], link, ac[17:0], mq[17:0]}
    localparam int NV = 14;
    localparam logic [45:0] VEC [NV] = '{
        {3'd0, 6'd1,  1'b1, 18'o000000, 18'o400000},
        {3'd0, 6'd36, 1'b0, 18'o123456, 18'o654321},
        {3'd0, 6'd0,  1'b1, 18'o111111, 18'o222222},
        {3'd1, 6'd3,  1'b0, 18'o456701, 18'o234567},
        {3'd2, 6'd1,  1'b1, 18'o000001, 18'o000000},
        {3'd2, 6'd20, 1'b0, 18'o707070, 18'o070707},
        {3'd3, 6'd5,  1'b0, 18'o400000, 18'o000000},
        {3'd4, 6'd1,  1'b1, 18'o400000, 18'o777777},
        {3'd4, 6'd18, 1'b0, 18'o525252, 18'o123123},
        {3'd5, 6'd36, 1'b0, 18'o000123, 18'o456000},
        {3'd6, 6'd36, 1'b0, 18'o777000, 18'o000000},
        {3'd5, 6'd1,  1'b0, 18'o200000, 18'o000000},
        {3'd5, 6'd0,  1'b0, 18'o000001, 18'o000000},
        {3'd2, 6'd36, 1'b1, 18'o000000, 18'o000000}
    };

    task automatic check(input string req, input string what,
                         input logic [63:0] got, input logic [63:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s %s: got %0h expected %0h", req, what, got, exp);
        end
    endtask

    function automatic string tag_of(input logic [2:0] op);
        case (op)
            3'd0:       return "R3";
            3'd1, 3'd3: return "R5";
            3'd2:       return "R4";
            3'd4:       return "R6";
            default:    return "R10";
        endcase
    endfunction

    // Reference behaviour built from the requirements.
    task automatic model(input logic [2:0] op, input logic [5:0] n,
                         input logic l, input logic [17:0] a, input logic [17:0] m,
                         output logic lo, output logic [17:0] ao, output logic [17:0] mo,
                         output logic [5:0] so, output int cyc);
        int k = 0;
        lo = l; ao = a; mo = m;
        if (op == 3'd1 || op == 3'd3 || op == 3'd6) lo = a[17];
        for (int i = 0; i < int'(n); i++) begin
            if ((op == 3'd5 || op == 3'd6) && (ao[17] != ao[16])) break;
            case (op)
                3'd2, 3'd3: {ao, mo} = {lo, ao, mo[17:1]};
                3'd4:       ao = {ao[16:0], lo};
                default:    {ao, mo} = {ao[16:0], mo, lo};
            endcase
            k++;
        end
        so  = 6'(k) - n;
        cyc = k + 2;
    endtask

    task automatic run_cmd(input logic [2:0] op, input logic [5:0] n, input logic l,
                           input logic [17:0] a, input logic [17:0] m, output int cyc);
        @(negedge clk);
        cmd_valid = 1'b1; cmd_op = op; cmd_count = n;
        cmd_link = l; cmd_ac = a; cmd_mq = m;
        @(negedge clk);
        cmd_valid = 1'b0;
        cyc = 0;
        while (busy && cyc < 500) begin
            cyc++;
            @(negedge clk);
        end
    endtask

    task automatic pulse_instr();
        instr_done = 1'b1;
        @(negedge clk);
        instr_done = 1'b0;
        @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic       el;
        logic [17:0] ea, em;
        logic [5:0] es;
        int ecyc, cyc;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        check("R1", "reset regs", {ac_out, mq_out, link_out, sc_out}, '0);
        check("R1", "reset flags", {busy, irq_hold}, 2'b00);

        // Table walk: R3 R4 R5 R6 R7 R8 R10 R11
        for (int v = 0; v < NV; v++) begin
            model(VEC[v][45:43], VEC[v][42:37], VEC[v][36], VEC[v][35:18], VEC[v][17:0],
                  el, ea, em, es, ecyc);
            run_cmd(VEC[v][45:43], VEC[v][42:37], VEC[v][36], VEC[v][35:18], VEC[v][17:0], cyc);
            check(tag_of(VEC[v][45:43]), "ac", ac_out, ea);
            check(tag_of(VEC[v][45:43]), "mq", mq_out, em);
            check(tag_of(VEC[v][45:43]), "link", link_out, el);
            check("R8", "sc", sc_out, es);
            check("R11", "busy length", cyc, ecyc);
        end

        // R5 / R7: hand-worked signed left by 3
        run_cmd(3'd1, 6'd3, 1'b0, 18'o456701, 18'o234567, cyc);
        check("R5", "signed left ac", ac_out, 18'o567012);
        check("R5", "signed left mq", mq_out, 18'o345677);
        check("R5", "signed left link", link_out, 1'b1);

        // R10: already normalized with count 1 leaves SC at 63; R9 clears it
        run_cmd(3'd5, 6'd1, 1'b0, 18'o200000, 18'o0, cyc);
        check("R10", "early stop sc", sc_out, 6'o77);
        check("R12", "hold after normalize", irq_hold, 1'b1);
        pulse_instr();
        check("R12", "hold after one instr", irq_hold, 1'b1);
        pulse_instr();
        check("R12", "hold after two instr", irq_hold, 1'b0);
        sc_clr = 1'b1;
        @(negedge clk);
        sc_clr = 1'b0;
        check("R9", "sc cleared", sc_out, 6'd0);

        // R12: plain shift releases hold with busy
        run_cmd(3'd0, 6'd4, 1'b0, 18'o1, 18'o0, cyc);
        check("R12", "no hold after shift", irq_hold, 1'b0);

        // R2: op code 7 ignored
        run_cmd(3'd7, 6'd5, 1'b1, 18'o777777, 18'o777777, cyc);
        check("R2", "op7 busy", cyc, 0);
        check("R2", "op7 regs", {ac_out, mq_out, link_out}, {18'o20, 18'o0, 1'b0});

        // R2: command while busy ignored
        model(3'd0, 6'd10, 1'b1, 18'o000777, 18'o123000, el, ea, em, es, ecyc);
        @(negedge clk);
        cmd_valid = 1'b1; cmd_op = 3'd0; cmd_count = 6'd10;
        cmd_link = 1'b1; cmd_ac = 18'o000777; cmd_mq = 18'o123000;
        @(negedge clk);
        cmd_op = 3'd4; cmd_count = 6'd1; cmd_ac = 18'o0; cmd_mq = 18'o0;
        repeat (3) @(negedge clk);
        cmd_valid = 1'b0;
        cyc = 0;
        while (busy && cyc < 500) begin
            cyc++;
            @(negedge clk);
        end
        check("R2", "busy cmd ignored ac", ac_out, ea);
        check("R2", "busy cmd ignored mq", mq_out, em);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule